// File: doc/BRIEF.md
# Three-Wire Serial Register Writer

This block sits on the host side of a peripheral that is configured over a three-wire link: a serial clock, a serial data line and a latch strobe. A write request carries a 21-bit payload and a 3-bit register-select code. The block joins them into a 24-bit word, sends that word most-significant bit first, and then raises the latch strobe to commit it inside the peripheral. The select code sits in the three lowest bits, so it goes out last.

Requests arrive on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its payload and select code are stored at that edge. `req_ready` stays low for the whole transfer, which is the only form of back-pressure. While `req_ready` is low, the requester must keep `req_valid` and its data steady. `busy` shows a transfer in flight. `done` pulses once when the word has been committed.

Every timing interval on the link is a parameter given in nanoseconds. The block converts each one into system-clock cycles, rounds up, and never uses fewer than one cycle. The serial clock and the latch strobe both idle low.

Top module: `tw_reg_writer`

## Requirements
- R1: Each accepted request produces exactly one word of 24 bits on `ser_data`, sent MSB first. The word is {req_payload[20:0], req_sel[2:0]}, so req_sel[2] is word bit 2 and req_sel[0] is word bit 0 (the final bit sent). Each bit is taken on a rising edge of `ser_clk`.
- R2: After reset, `ser_clk`, `ser_le`, `busy` and `done` are low and `req_ready` is high.
- R3: `ser_data` holds its value for at least the data-setup interval (in cycles) before every rising edge of `ser_clk`. It changes only while `ser_clk` is low, which gives the hold time.
- R4: Every high phase of `ser_clk` lasts at least the clock-high interval. Every low phase between two rising edges of one word lasts at least the clock-low interval.
- R5: `ser_le` rises only after exactly 24 rising edges of `ser_clk`, and no sooner than the latch-setup interval after the last falling edge of `ser_clk`. `ser_clk` stays low while `ser_le` is high.
- R6: `ser_le` stays high for at least the latch-width interval.
- R7: `ser_le` stays low for at least the latch-gap interval before the first rising edge of `ser_clk` of any word, including when requests arrive back to back.
- R8: A request is taken only when `req_valid` and `req_ready` are both high, and `req_ready` is the inverse of `busy`. `busy` is high from the cycle after acceptance until the word is committed. A request held while busy waits, and is accepted once ready returns.
- R9: `done` is high for exactly one cycle: the first cycle in which `ser_le` is low again after the latch pulse. In that same cycle `busy` is low and `req_ready` is high.
- R10: With `req_valid` low, changes on `req_payload` or `req_sel` cause no activity on `ser_clk` or `ser_le`. Changes after acceptance do not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request |
| req_payload | input | 21 | Register payload, word bits 23..3 |
| req_sel | input | 3 | Register-select code, word bits 2..0 |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data |
| ser_le | output | 1 | Latch strobe, idles low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the word is committed |

## Verification
The `done` pulse that ends one word and the acceptance of the next request can fall in the same cycle, because `req_ready` rises in the cycle where `done` is high. The bench provokes this by holding the next request valid while the block is busy, so that request is accepted on the edge that follows the end of the latch pulse. The bench then checks three things. `done` lasted exactly one cycle and `req_ready` was high during it. The word that was committed matches the first request. The next word's first rising clock edge still respects the latch-gap interval counted from the falling edge of the strobe.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_HIGH,
    S_LOW,
    S_TAIL,
    S_LATCH
  } tw_state_e;

  // Converts a time in ns to system-clock cycles, rounded up, minimum one cycle.
  function automatic int ns_to_cycles(input int t_ns, input int clk_ps);
    int c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tw_interval_timer.sv
module tw_interval_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4: the counter parks at zero until it is reloaded
  a_r4_timer_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);

  // R4: without a reload, a running count steps down by one each cycle
  a_r4_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/tw_shift_out.sv
module tw_shift_out #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb,
  output logic              last_bit
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= load_word;
      left_q <= CNT_W'(WORD_W);
    end else if (shift) begin
      sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign msb      = sh_q[WORD_W-1];
  assign last_bit = (left_q == CNT_W'(1));

  // R1: a freshly captured word has all of its bits still to go
  a_r1_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (left_q == CNT_W'(WORD_W)));

  // R1: no shift happens once the final bit is on the line
  a_r1_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (!last_bit && left_q != '0));

endmodule

// File: rtl/tw_seq_ctrl.sv
module tw_seq_ctrl
  import tw_pkg::*;
#(
  parameter int CW      = 4,
  parameter int LEAD_N  = 1,
  parameter int HIGH_N  = 1,
  parameter int LOW_N   = 1,
  parameter int TAIL_N  = 1,
  parameter int LATCH_N = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          t_expired,
  input  logic          last_bit,
  output logic          t_load,
  output logic [CW-1:0] t_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          ser_clk,
  output logic          ser_le,
  output logic          busy,
  output logic          done
);

  localparam logic [CW-1:0] LEAD_V  = CW'(LEAD_N - 1);
  localparam logic [CW-1:0] HIGH_V  = CW'(HIGH_N - 1);
  localparam logic [CW-1:0] LOW_V   = CW'(LOW_N - 1);
  localparam logic [CW-1:0] TAIL_V  = CW'(TAIL_N - 1);
  localparam logic [CW-1:0] LATCH_V = CW'(LATCH_N - 1);

  tw_state_e state_q, state_d;
  logic clk_q, clk_d, le_q, le_d, busy_q, busy_d, done_q, done_d;

  always_comb begin
    state_d  = state_q;
    clk_d    = clk_q;
    le_d     = le_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    t_load   = 1'b0;
    t_val    = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        sh_load = 1'b1;
        t_load  = 1'b1;
        t_val   = LEAD_V;
        busy_d  = 1'b1;
        state_d = S_LEAD;
      end
      S_LEAD: if (t_expired) begin
        clk_d   = 1'b1;
        t_load  = 1'b1;
        t_val   = HIGH_V;
        state_d = S_HIGH;
      end
      S_HIGH: if (t_expired) begin
        clk_d  = 1'b0;
        t_load = 1'b1;
        if (last_bit) begin
          t_val   = TAIL_V;
          state_d = S_TAIL;
        end else begin
          sh_shift = 1'b1;
          t_val    = LOW_V;
          state_d  = S_LOW;
        end
      end
      S_LOW: if (t_expired) begin
        clk_d   = 1'b1;
        t_load  = 1'b1;
        t_val   = HIGH_V;
        state_d = S_HIGH;
      end
      S_TAIL: if (t_expired) begin
        le_d    = 1'b1;
        t_load  = 1'b1;
        t_val   = LATCH_V;
        state_d = S_LATCH;
      end
      S_LATCH: if (t_expired) begin
        le_d    = 1'b0;
        busy_d  = 1'b0;
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      clk_q   <= 1'b0;
      le_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      clk_q   <= clk_d;
      le_q    <= le_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign req_ready = !busy_q;
  assign ser_clk   = clk_q;
  assign ser_le    = le_q;
  assign busy      = busy_q;
  assign done      = done_q;

  // R5: the strobe never overlaps a serial clock high phase
  a_r5_le_clk_apart: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk);

  // R3: the data register only moves on a falling serial clock
  a_r3_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    sh_shift |-> ser_clk);

  // R8: an accepted request makes the block busy in the next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R9: done is a single-cycle pulse with busy already released
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_free: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $fell(ser_le)));

  // R2: an idle block keeps both link strobes low
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_le));

endmodule

// File: rtl/tw_reg_writer.sv
module tw_reg_writer
  import tw_pkg::*;
#(
  parameter int PAYLOAD_W       = 21,
  parameter int SEL_W           = 3,
  parameter int SYS_CLK_PS      = 20000,
  parameter int T_DATA_SETUP_NS = 10,
  parameter int T_DATA_HOLD_NS  = 10,
  parameter int T_CLK_HIGH_NS   = 25,
  parameter int T_CLK_LOW_NS    = 25,
  parameter int T_LE_SETUP_NS   = 10,
  parameter int T_LE_WIDTH_NS   = 20,
  parameter int T_LE_GAP_NS     = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PAYLOAD_W-1:0] req_payload,
  input  logic [SEL_W-1:0]     req_sel,
  output logic                 ser_clk,
  output logic                 ser_data,
  output logic                 ser_le,
  output logic                 busy,
  output logic                 done
);

  localparam int WORD_W = PAYLOAD_W + SEL_W;

  localparam int SU_C   = ns_to_cycles(T_DATA_SETUP_NS, SYS_CLK_PS);
  localparam int HD_C   = ns_to_cycles(T_DATA_HOLD_NS,  SYS_CLK_PS);
  localparam int HI_C   = ns_to_cycles(T_CLK_HIGH_NS,   SYS_CLK_PS);
  localparam int LO_C   = ns_to_cycles(T_CLK_LOW_NS,    SYS_CLK_PS);
  localparam int LESU_C = ns_to_cycles(T_LE_SETUP_NS,   SYS_CLK_PS);
  localparam int LEW_C  = ns_to_cycles(T_LE_WIDTH_NS,   SYS_CLK_PS);
  localparam int GAP_C  = ns_to_cycles(T_LE_GAP_NS,     SYS_CLK_PS);

  // Per-state dwell lengths: each covers every rule that bounds that phase.
  localparam int LEAD_N  = max_i(max_i(SU_C, LO_C), GAP_C);
  localparam int HIGH_N  = max_i(HI_C, HD_C);
  localparam int LOW_N   = max_i(LO_C, SU_C);
  localparam int TAIL_N  = LESU_C;
  localparam int LATCH_N = LEW_C;
  localparam int MAX_N   = max_i(max_i(max_i(LEAD_N, HIGH_N), max_i(LOW_N, TAIL_N)), LATCH_N);
  localparam int CW      = (MAX_N <= 2) ? 1 : $clog2(MAX_N);

  logic          t_load, t_expired, sh_load, sh_shift, last_bit;
  logic [CW-1:0] t_val;

  tw_seq_ctrl #(
    .CW(CW), .LEAD_N(LEAD_N), .HIGH_N(HIGH_N), .LOW_N(LOW_N),
    .TAIL_N(TAIL_N), .LATCH_N(LATCH_N)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .t_expired(t_expired), .last_bit(last_bit),
    .t_load(t_load), .t_val(t_val),
    .sh_load(sh_load), .sh_shift(sh_shift),
    .ser_clk(ser_clk), .ser_le(ser_le),
    .busy(busy), .done(done)
  );

  tw_interval_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  tw_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(sh_load), .load_word({req_payload, req_sel}),
    .shift(sh_shift), .msb(ser_data), .last_bit(last_bit)
  );

  // R3: data never moves on the edge where the serial clock rises
  a_r3_data_still_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  // R5: the strobe rises only from a low serial clock
  a_r5_le_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_le) |-> ($past(ser_clk) == 1'b0));

endmodule

// File: tb/tw_reg_writer_tb.sv
`timescale 1ns/1ps
module tw_reg_writer_tb;

  localparam int CLK_PS = 20000;
  localparam int SU_NS = 30, HD_NS = 10, HI_NS = 50, LO_NS = 45;
  localparam int LESU_NS = 50, LEW_NS = 70, GAP_NS = 110;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_SU = cyc(SU_NS), N_HI = cyc(HI_NS), N_LO = cyc(LO_NS);
  localparam int N_LESU = cyc(LESU_NS), N_LEW = cyc(LEW_NS), N_GAP = cyc(GAP_NS);

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [20:0] req_payload = '0;
  logic [2:0]  req_sel = '0;
  logic        req_ready, ser_clk, ser_data, ser_le, busy, done;

  always #10 clk = ~clk;

  tw_reg_writer #(
    .SYS_CLK_PS(CLK_PS), .T_DATA_SETUP_NS(SU_NS), .T_DATA_HOLD_NS(HD_NS),
    .T_CLK_HIGH_NS(HI_NS), .T_CLK_LOW_NS(LO_NS), .T_LE_SETUP_NS(LESU_NS),
    .T_LE_WIDTH_NS(LEW_NS), .T_LE_GAP_NS(GAP_NS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_payload(req_payload), .req_sel(req_sel), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_le(ser_le), .busy(busy), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  logic [23:0] exp_q[$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: rebuilds each word from the link and times every phase.
  logic pclk = 0, ple = 0, pdata = 0;
  int stab = 0, hi = 0, lo = 0, since_fall = 0, lew = 0, gap = 1000, bits = 0;
  bit first = 1;
  logic [23:0] word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && !pclk) begin
        chk(stab >= N_SU, "R3 data setup before rise", stab, N_SU);
        if (first) chk(gap >= N_GAP, "R7 strobe gap before first rise", gap, N_GAP);
        else       chk(lo >= N_LO, "R4 clock low phase", lo, N_LO);
        first = 0;
        word = {word[22:0], ser_data};
        bits++;
      end
      if (!ser_clk && pclk) chk(hi >= N_HI, "R4 clock high phase", hi, N_HI);
      if (ser_data !== pdata) chk(ser_clk == 1'b0, "R3 data moved while clock high", ser_clk, 0);
      if (ser_clk || ser_le) chk(busy === 1'b1 && req_ready === 1'b0, "R8 busy and not ready in transfer", {busy, req_ready}, 2'b10);
      if (ser_le) chk(!ser_clk, "R5 clock low while strobe high", ser_clk, 0);
      if (ser_le && !ple) begin
        chk(since_fall >= N_LESU, "R5 strobe setup after last fall", since_fall, N_LESU);
        chk(bits == 24, "R5 rising edges per word", bits, 24);
        if (exp_q.size() == 0) chk(0, "R10 word with no request", word, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(word == e, "R1 committed word", word, e);
        end
        bits = 0;
        first = 1;
      end
      if (!ser_le && ple) begin
        chk(lew >= N_LEW, "R6 strobe width", lew, N_LEW);
        chk(done === 1'b1, "R9 done in first cycle after strobe", done, 1);
        chk(req_ready === 1'b1 && busy === 1'b0, "R9 ready with done", {busy, req_ready}, 2'b01);
      end else if (done !== 1'b0) begin
        chk(0, "R9 done outside its slot", done, 0);
      end
      stab       = (ser_data !== pdata) ? 1 : stab + 1;
      hi         = ser_clk ? hi + 1 : 0;
      lo         = ser_clk ? 0 : lo + 1;
      since_fall = ser_clk ? 0 : since_fall + 1;
      lew        = ser_le ? lew + 1 : 0;
      gap        = ser_le ? 0 : gap + 1;
      pclk = ser_clk; ple = ser_le; pdata = ser_data;
    end
  end

  // Driver: starts at a negedge, records the expected word at acceptance.
  task automatic send(input logic [20:0] p, input logic [2:0] s);
    req_valid = 1'b1; req_payload = p; req_sel = s;
    while (req_ready !== 1'b1) @(negedge clk);
    @(posedge clk);
    exp_q.push_back({p, s});
    @(negedge clk);
    chk(busy === 1'b1, "R8 busy after acceptance", busy, 1);
    req_valid = 1'b0;
    req_payload = 21'($urandom);   // R10: later changes must not reach the word
    req_sel = 3'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_clk === 0 && ser_le === 0, "R2 link idle in reset", {ser_clk, ser_le}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_clk === 0 && ser_le === 0, "R2 link idle after reset", {ser_clk, ser_le}, 0);
    chk(busy === 0 && done === 0, "R2 busy and done low", {busy, done}, 0);
    chk(req_ready === 1, "R2 ready after reset", req_ready, 1);

    send(21'h1FFFFF, 3'b111);
    send(21'h000000, 3'b000);
    send(21'h155555, 3'b010);
    send(21'h0AAAAA, 3'b101);
    for (int s = 0; s < 8; s++) send(21'($urandom), 3'(s));
    while (busy) @(negedge clk);

    // R10: no valid, busy inputs toggling
    for (int i = 0; i < 60; i++) begin
      req_payload = 21'($urandom);
      req_sel = 3'($urandom);
      @(negedge clk);
      chk(!ser_clk && !ser_le && !busy, "R10 no activity without valid", {ser_clk, ser_le, busy}, 0);
    end

    send(21'h12345A, 3'b100);
    send(21'h0F0F0F, 3'b001);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R1 every accepted word delivered", exp_q.size(), 0);
    finish_run();
  end

endmodule